// File: doc/BRIEF.md
# Network Interface Control and Parity Capture Registers

This block holds the control and status registers of a bus-attached network interface board. Software uses a 16-bit register port to drive the board-level reset, the channel-attention line toward the network controller, the choice between loopback and live network, the auxiliary bus enable, and two interrupt enables. The status word also shows the controller's interrupt request, a parity-error flag, a RAM-size strap and four host address bits that software needs to locate the RAM window.

When the buffer RAM reports a parity error, the block latches the 20-bit failing address, the error source and the failing byte end. It then raises the parity flag and holds all of them until software writes an acknowledge. The interrupt output combines the controller request and the parity flag, each gated by its own enable.

Top module: `netif_ctrl_regs`

## Requirements
- R1: After reset, every writable control bit, the parity flag and the captured fields are 0, so board_rst, live_sel, chan_attn, aux_bus_en and irq_out are all 0.
- R2: A write to select 0 (status) stores bits 15 (board reset), 14 (live line), 13 (attention), 12 (controller interrupt enable), 11 (parity interrupt enable) and 5 (auxiliary bus enable). The stored bits appear on the outputs and on readback from the next cycle. The remaining bits of the write are discarded.
- R3: Channel attention is a level. Once written to 1 it stays asserted on chan_attn until software writes it back to 0. Writes to other selects do not change it.
- R4: Status readback shows the parity flag in bit 9, the live ctl_irq input in bit 8, strap_256k in bit 4 and strap_win in bits 3:0. Bits 10, 7 and 6 read 0.
- R5: A parity error that arrives while the flag is clear sets the flag on the next cycle. Select 1 then reads the source in bit 7, the byte end in bit 6 and address bits 19:16 in bits 3:0. Select 2 reads address bits 15:0.
- R6: While the flag is set, further parity errors do not change the captured address, source or byte end.
- R7: Writing select 1 with bit 8 set clears the flag on the next cycle. Bit 8 always reads 0. A write to select 1 with bit 8 clear has no effect. If a new error arrives in the same cycle as the acknowledge, the new error is captured and the flag stays set.
- R8: irq_out is 1 exactly when (ctl_irq and the controller interrupt enable) or (the parity flag and the parity interrupt enable).
- R9: Writes to select 2 and select 3 change no state. Select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 parity control, 2 parity low address, 3 unused |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| par_err | input | 1 | Parity error reported by the buffer RAM this cycle |
| par_addr | input | 20 | Failing RAM address |
| par_src | input | 1 | Error source indication |
| par_end | input | 1 | Failing byte end |
| ctl_irq | input | 1 | Interrupt request from the network controller |
| strap_256k | input | 1 | RAM device size strap |
| strap_win | input | 4 | Host address bits locating the RAM window |
| board_rst | output | 1 | Board reset to the controller |
| live_sel | output | 1 | 1 selects the live network, 0 loopback |
| chan_attn | output | 1 | Channel attention level |
| aux_bus_en | output | 1 | Auxiliary bus enable |
| irq_out | output | 1 | Combined interrupt |

## Verification
The assertions assume that par_err, par_addr, par_src, par_end and the register port inputs are synchronous to clk and are at valid levels at every rising edge once reset is released. The stimulus changes all inputs only on the falling edge, so each value is stable around the active edge. The random phase deliberately lets errors collide with acknowledges and with a flag that is already set. This exercises the priority and hold rules that the assertions guard.

// File: rtl/netif_ctrl_pkg.sv
package netif_ctrl_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_PCTL = 2'd1,
    SEL_PLOW = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // status word bit positions
  localparam int B_RST    = 15;
  localparam int B_LIVE   = 14;
  localparam int B_ATTN   = 13;
  localparam int B_IE_CTL = 12;
  localparam int B_IE_PAR = 11;
  localparam int B_PFLAG  = 9;
  localparam int B_IFLAG  = 8;
  localparam int B_AUX    = 5;
  localparam int B_256K   = 4;
  localparam int WIN_W    = 4;

  // parity control bit positions
  localparam int P_ACK = 8;
  localparam int P_SRC = 7;
  localparam int P_END = 6;

  typedef struct packed {
    logic rst;
    logic live;
    logic attn;
    logic ie_ctl;
    logic ie_par;
    logic aux;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.rst    = w[B_RST];
    c.live   = w[B_LIVE];
    c.attn   = w[B_ATTN];
    c.ie_ctl = w[B_IE_CTL];
    c.ie_par = w[B_IE_PAR];
    c.aux    = w[B_AUX];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input ctrl_t c, input logic pflag,
                                                   input logic iflag, input logic big,
                                                   input logic [WIN_W-1:0] win);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_RST]    = c.rst;
    w[B_LIVE]   = c.live;
    w[B_ATTN]   = c.attn;
    w[B_IE_CTL] = c.ie_ctl;
    w[B_IE_PAR] = c.ie_par;
    w[B_PFLAG]  = pflag;
    w[B_IFLAG]  = iflag;
    w[B_AUX]    = c.aux;
    w[B_256K]   = big;
    w[WIN_W-1:0] = win;
    return w;
  endfunction
endpackage

// File: rtl/netif_ctrl_bits.sv
module netif_ctrl_bits
  import netif_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stat,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_stat) ctrl_q <= unpack_ctrl(wdata);
  end

  // attention and the other control levels only move on a status write
  p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> $stable(ctrl_q));
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ctrl_q.attn == $past(wdata[B_ATTN]));
endmodule

// File: rtl/netif_par_latch.sv
module netif_par_latch #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_in,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              err_src,
  input  logic              err_end,
  input  logic              ack,
  output logic              flag_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              src_q,
  output logic              end_q
);
  logic take;
  assign take = err_in && (!flag_q || ack);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      src_q  <= 1'b0;
      end_q  <= 1'b0;
    end else if (take) begin
      flag_q <= 1'b1;
      addr_q <= err_addr;
      src_q  <= err_src;
      end_q  <= err_end;
    end else if (ack) begin
      flag_q <= 1'b0;
    end
  end

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_in && !flag_q) |=> (flag_q && addr_q == $past(err_addr)));
  p_first_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack) |=> (flag_q && $stable(addr_q) && $stable(src_q) && $stable(end_q)));
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !err_in) |=> !flag_q);
  p_ack_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && err_in) |=> flag_q);
endmodule

// File: rtl/netif_irq_merge.sv
module netif_irq_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_req,
  input  logic ctl_en,
  input  logic par_flag,
  input  logic par_en,
  output logic irq
);
  assign irq = (ctl_req & ctl_en) | (par_flag & par_en);

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !par_en) |-> !irq);
  p_par_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (par_flag && par_en) |-> irq);
endmodule

// File: rtl/netif_ctrl_regs.sv
module netif_ctrl_regs
  import netif_ctrl_pkg::*;
#(
  parameter int PAR_ADDR_W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [1:0]            reg_sel,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic                  par_err,
  input  logic [PAR_ADDR_W-1:0] par_addr,
  input  logic                  par_src,
  input  logic                  par_end,
  input  logic                  ctl_irq,
  input  logic                  strap_256k,
  input  logic [WIN_W-1:0]      strap_win,
  output logic                  board_rst,
  output logic                  live_sel,
  output logic                  chan_attn,
  output logic                  aux_bus_en,
  output logic                  irq_out
);
  localparam int LOW_W = 16;
  localparam int HI_W  = PAR_ADDR_W - LOW_W;

  ctrl_t                 ctrl_q;
  logic                  wr_stat, ack_w;
  logic                  pflag;
  logic [PAR_ADDR_W-1:0] paddr;
  logic                  psrc, pend;

  assign wr_stat = reg_we && (reg_sel == SEL_STAT);
  assign ack_w   = reg_we && (reg_sel == SEL_PCTL) && reg_wdata[P_ACK];

  netif_ctrl_bits u_bits (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wdata(reg_wdata), .ctrl_q(ctrl_q)
  );

  netif_par_latch #(.ADDR_W(PAR_ADDR_W)) u_par (
    .clk(clk), .rst_n(rst_n), .err_in(par_err), .err_addr(par_addr),
    .err_src(par_src), .err_end(par_end), .ack(ack_w),
    .flag_q(pflag), .addr_q(paddr), .src_q(psrc), .end_q(pend)
  );

  netif_irq_merge u_irq (
    .clk(clk), .rst_n(rst_n), .ctl_req(ctl_irq), .ctl_en(ctrl_q.ie_ctl),
    .par_flag(pflag), .par_en(ctrl_q.ie_par), .irq(irq_out)
  );

  assign board_rst  = ctrl_q.rst;
  assign live_sel   = ctrl_q.live;
  assign chan_attn  = ctrl_q.attn;
  assign aux_bus_en = ctrl_q.aux;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel_e'(reg_sel))
      SEL_STAT: reg_rdata = pack_status(ctrl_q, pflag, ctl_irq, strap_256k, strap_win);
      SEL_PCTL: begin
        reg_rdata[P_SRC]    = psrc;
        reg_rdata[P_END]    = pend;
        reg_rdata[HI_W-1:0] = paddr[PAR_ADDR_W-1:LOW_W];
      end
      SEL_PLOW: reg_rdata = paddr[LOW_W-1:0];
      SEL_NONE: reg_rdata = '0;
    endcase
  end

  p_ack_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_PCTL) |-> !reg_rdata[P_ACK]);
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_NONE) |-> (reg_rdata == '0));
  p_attn_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel != SEL_STAT) |=> $stable(chan_attn));
endmodule

// File: tb/test_netif_ctrl_regs.sv
module test_netif_ctrl_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_sel = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        par_err = 0;
  logic [19:0] par_addr = 0;
  logic        par_src = 0, par_end = 0, ctl_irq = 0, strap_256k = 0;
  logic [3:0]  strap_win = 0;
  logic        board_rst, live_sel, chan_attn, aux_bus_en, irq_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [15:0] m_ctl = 0;   // stored status bits under mask 16'hF820
  logic        m_flag = 0, m_src = 0, m_end = 0;
  logic [19:0] m_addr = 0;

  always #10 clk = ~clk;

  netif_ctrl_regs i_netif_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .par_err(par_err), .par_addr(par_addr), .par_src(par_src),
    .par_end(par_end), .ctl_irq(ctl_irq), .strap_256k(strap_256k), .strap_win(strap_win),
    .board_rst(board_rst), .live_sel(live_sel), .chan_attn(chan_attn),
    .aux_bus_en(aux_bus_en), .irq_out(irq_out)
  );

  function automatic logic [15:0] exp_status();
    return m_ctl | {6'b0, m_flag, ctl_irq, 3'b0, strap_256k, strap_win};
  endfunction

  function automatic logic [15:0] exp_pctl();
    return {8'b0, m_src, m_end, 2'b0, m_addr[19:16]};
  endfunction

  function automatic logic exp_irq();
    return (ctl_irq && m_ctl[12]) || (m_flag && m_ctl[11]);
  endfunction

  task automatic chk(input string tag, input string what, input logic [19:0] got,
                     input logic [19:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    reg_we = 0;
    for (int s = 0; s < 4; s++) begin
      reg_sel = s[1:0];
      #1;
      case (s)
        0: chk({tag, "/R2/R4"}, "status", 20'(reg_rdata), 20'(exp_status()));
        1: chk({tag, "/R5/R7"}, "parity ctl", 20'(reg_rdata), 20'(exp_pctl()));
        2: chk({tag, "/R5"}, "parity low", 20'(reg_rdata), 20'(m_addr[15:0]));
        default: chk({tag, "/R9"}, "unused", 20'(reg_rdata), 20'd0);
      endcase
    end
    chk({tag, "/R2"}, "board_rst", 20'(board_rst), 20'(m_ctl[15]));
    chk({tag, "/R2"}, "live_sel", 20'(live_sel), 20'(m_ctl[14]));
    chk({tag, "/R3"}, "chan_attn", 20'(chan_attn), 20'(m_ctl[13]));
    chk({tag, "/R2"}, "aux_bus_en", 20'(aux_bus_en), 20'(m_ctl[5]));
    chk({tag, "/R8"}, "irq_out", 20'(irq_out), 20'(exp_irq()));
  endtask

  // check current state, then drive one cycle of inputs and advance the model
  task automatic do_cycle(input string tag, input logic we, input logic [1:0] sel,
                          input logic [15:0] wd, input logic err, input logic [19:0] ea,
                          input logic es, input logic ee, input logic ci,
                          input logic big, input logic [3:0] win);
    logic ack;
    @(negedge clk);
    check_all(tag);
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    par_err = err; par_addr = ea; par_src = es; par_end = ee;
    ctl_irq = ci; strap_256k = big; strap_win = win;
    ack = we && sel == 2'd1 && wd[8];
    if (we && sel == 2'd0) m_ctl = wd & 16'hF820;
    if (err && (!m_flag || ack)) begin
      m_flag = 1; m_addr = ea; m_src = es; m_end = ee;
    end else if (ack) m_flag = 0;
  endtask

  task automatic idle(input string tag);
    do_cycle(tag, 0, 2'd0, 16'h0, 0, 20'h0, 0, 0, ctl_irq, strap_256k, strap_win);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    idle("R1");
    // R2: write all ones, only stored bits survive
    do_cycle("R2", 1, 2'd0, 16'hFFFF, 0, 20'h0, 0, 0, 0, 1, 4'hA);
    idle("R2");
    // R3: attention alone set, held across other writes
    do_cycle("R3", 1, 2'd0, 16'h2000, 0, 20'h0, 0, 0, 0, 0, 4'h3);
    do_cycle("R3", 1, 2'd1, 16'hFEFF, 0, 20'h0, 0, 0, 0, 0, 4'h3);
    do_cycle("R3", 1, 2'd2, 16'hFFFF, 0, 20'h0, 0, 0, 0, 0, 4'h3);
    idle("R3");
    do_cycle("R3", 1, 2'd0, 16'h0000, 0, 20'h0, 0, 0, 1, 0, 4'h3);
    // R4/R8: controller irq shown and gated by enable
    do_cycle("R8", 1, 2'd0, 16'h1000, 0, 20'h0, 0, 0, 1, 0, 4'h5);
    idle("R8");
    // R5: capture
    do_cycle("R5", 0, 2'd0, 16'h0, 1, 20'hA_BCDE, 1, 0, 0, 0, 4'h5);
    idle("R5");
    // R6: second error ignored
    do_cycle("R6", 0, 2'd0, 16'h0, 1, 20'h1_2345, 0, 1, 0, 0, 4'h5);
    idle("R6");
    // R8: parity interrupt
    do_cycle("R8", 1, 2'd0, 16'h0800, 0, 20'h0, 0, 0, 0, 0, 4'h5);
    idle("R8");
    // R7: write without ack bit has no effect, then ack
    do_cycle("R7", 1, 2'd1, 16'hFEFF, 0, 20'h0, 0, 0, 0, 0, 4'h5);
    do_cycle("R7", 1, 2'd1, 16'h0100, 0, 20'h0, 0, 0, 0, 0, 4'h5);
    idle("R7");
    // R7: error and ack collide
    do_cycle("R7", 0, 2'd0, 16'h0, 1, 20'hF_0F0F, 0, 0, 0, 0, 4'h5);
    do_cycle("R7", 1, 2'd1, 16'h0100, 1, 20'h7_7777, 1, 1, 0, 0, 4'h5);
    idle("R7");
    // R9: writes to low address and unused select
    do_cycle("R9", 1, 2'd2, 16'h1234, 0, 20'h0, 0, 0, 0, 0, 4'h5);
    do_cycle("R9", 1, 2'd3, 16'hFFFF, 0, 20'h0, 0, 0, 0, 0, 4'h5);
    idle("R9");
    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      do_cycle("RND", r[0] & r[1], r[3:2], 16'($urandom) | (r[4] ? 16'h0100 : 16'h0),
               (r[7:5] == 3'd0), 20'($urandom), r[8], r[9], r[10], r[11], r[15:12]);
    end
    idle("RND");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule